// File: doc/BRIEF.md
# Priority Interrupt Controller with In-Service Tracking

This block collects single-cycle request pulses from a parameterised number of maskable sources and presents the CPU with one interrupt at a time: the source number and its priority level. Each source keeps a pending flag, a mask bit and a three-bit level. Software reaches that state over a byte-wide register bus that can write whole bytes or set or clear a single bit. It can also read one addressed bit back.

Every source has a control byte. The mask bits can also be reached as a packed bank, eight sources per byte, and both views share one set of flops. A one-byte in-service register records which levels are being handled. A request is offered only when its level is strictly more urgent than every level in service. The CPU acknowledges with `irq_ack`, which moves the winner from pending to in service. It finishes with `eoi`, which retires the most urgent in-service level.

Top module: `prio_intc`

## Requirements
- R1: After reset every pending flag is 0, every mask bit is 1, the in-service byte reads 0x00 and `irq_valid` is low.
- R2: The control byte of source n is at `CTRL_BASE + 2*n`. Bit 7 is the pending flag, bit 6 is the mask bit (1 = disabled) and bits 2:0 are the level. Bits 5:3 are not stored and read 0.
- R3: The mask byte at `MASK_BASE + (n>>3)` holds source n at bit `n & 7` (1 = masked). It is the same storage as bit 6 of the control bytes, so a write through either view shows in both.
- R4: A request pulse on a masked source sets its pending flag but raises no interrupt. Clearing the mask then delivers it, unless software has first cleared bit 7.
- R5: Among the eligible sources, the lowest level number wins. On a tie, the lowest source number wins.
- R6: A pending, unmasked source is eligible only when its level is numerically below every set bit of the in-service byte. A level equal to or above one in service is held off.
- R7: `irq_ack` while `irq_valid` is high clears the winner's pending flag and sets the in-service bit of the winner's level.
- R8: `eoi` clears the lowest-numbered set bit of the in-service byte.
- R9: Bus op 0 writes the whole byte, op 1 sets and op 2 clears only bit `bus_bit` of the addressed byte, and op 3 changes nothing. `bus_bit_rd` returns bit `bus_bit` of the byte at `bus_addr`.
- R10: The in-service byte at `ISR_ADDR` is read-only, so bus writes to it have no effect.
- R11: A request pulse in the same cycle as a bus clear or an acknowledge of the same source leaves its pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | NUM_SRC | One-cycle request per source |
| bus_wr | input | 1 | Bus write strobe |
| bus_op | input | 2 | 0 byte write, 1 bit set, 2 bit clear, 3 no-op |
| bus_addr | input | ADDR_W | Byte address |
| bus_bit | input | 3 | Bit index for set, clear and bit read |
| bus_wdata | input | 8 | Write data for byte writes |
| bus_rdata | output | 8 | Byte at bus_addr (combinational) |
| bus_bit_rd | output | 1 | Bit bus_bit of bus_rdata |
| irq_valid | output | 1 | An eligible request is offered |
| irq_src | output | $clog2(NUM_SRC) | Winning source number |
| irq_level | output | 3 | Winning level |
| irq_ack | input | 1 | CPU accepts the offered request |
| eoi | input | 1 | End of the most urgent in-service level |

## Verification
The bench builds the controller with `NUM_SRC = 16`. This keeps every control byte and both mask-bank bytes small enough to visit directly. At the default width the same address decode covers 64 sources. Sixteen sources still span two mask bytes, so a whole-byte mask write to the upper bank can be checked against control bytes of the sources it covers. Two nested in-service levels are driven through acknowledge and end-of-interrupt, which shows that equal levels are held off and that retiring a level releases the next one.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    localparam int LVL_W   = 3;
    localparam int NUM_LVL = 1 << LVL_W;

    typedef enum logic [1:0] {
        OP_BYTE = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_NONE = 2'd3
    } bus_op_e;

    typedef struct packed {
        logic             pend;
        logic             mask;
        logic [LVL_W-1:0] lvl;
    } src_state_t;

    // Resulting byte after a bus operation on an existing byte.
    function automatic logic [7:0] apply_op(input logic [1:0] op,
                                            input logic [7:0] cur,
                                            input logic [7:0] wd,
                                            input logic [2:0] idx);
        logic [7:0] r;
        r = cur;
        case (op)
            OP_BYTE: r = wd;
            OP_SET:  r[idx] = 1'b1;
            OP_CLR:  r[idx] = 1'b0;
            default: r = cur;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] ctrl_byte(input src_state_t s);
        return {s.pend, s.mask, 3'b000, s.lvl};
    endfunction

endpackage

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC   = 64,
    parameter int ADDR_W    = 8,
    parameter int CTRL_BASE = 'h00,
    parameter int MASK_BASE = 'h80,
    parameter int ISR_ADDR  = 'hFF,
    localparam int SRC_W    = $clog2(NUM_SRC),
    localparam int N_MBYTE  = NUM_SRC / 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_SRC-1:0]           src_pulse,
    input  logic                         bus_wr,
    input  logic [1:0]                   bus_op,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [2:0]                   bus_bit,
    input  logic [7:0]                   bus_wdata,
    input  logic                         ack_fire,
    input  logic [SRC_W-1:0]             ack_src,
    input  logic [NUM_LVL-1:0]           isr,
    output src_state_t [NUM_SRC-1:0]     st_q,
    output logic [7:0]                   bus_rdata,
    output logic                         bus_bit_rd
);

    src_state_t [NUM_SRC-1:0] st_d;
    logic [NUM_SRC-1:0]       mask_vec;
    logic [NUM_SRC-1:0]       pend_vec;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            mask_vec[i] = st_q[i].mask;
            pend_vec[i] = st_q[i].pend;
        end
    end

    always_comb begin
        logic [7:0] nb;
        st_d = st_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            nb = '0;
            if (bus_wr && bus_addr == ADDR_W'(CTRL_BASE + 2*i)) begin
                nb = apply_op(bus_op, ctrl_byte(st_q[i]), bus_wdata, bus_bit);
                st_d[i].pend = nb[7];
                st_d[i].mask = nb[6];
                st_d[i].lvl  = nb[LVL_W-1:0];
            end
            if (bus_wr && bus_addr == ADDR_W'(MASK_BASE + i/8)) begin
                nb = apply_op(bus_op, mask_vec[(i/8)*8 +: 8], bus_wdata, bus_bit);
                st_d[i].mask = nb[i%8];
            end
            if (ack_fire && ack_src == SRC_W'(i))
                st_d[i].pend = 1'b0;
            if (src_pulse[i])
                st_d[i].pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SRC; i++)
                st_q[i] <= '{pend: 1'b0, mask: 1'b1, lvl: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++)
            if (bus_addr == ADDR_W'(CTRL_BASE + 2*i))
                bus_rdata = ctrl_byte(st_q[i]);
        for (int k = 0; k < N_MBYTE; k++)
            if (bus_addr == ADDR_W'(MASK_BASE + k))
                bus_rdata = mask_vec[k*8 +: 8];
        if (bus_addr == ADDR_W'(ISR_ADDR))
            bus_rdata = isr;
    end

    assign bus_bit_rd = bus_rdata[bus_bit];

    // R1: state right after reset
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_vec == '1 && pend_vec == '0));

    // R11: a request pulse always leaves its pending flag set
    p_pulse_sets_pend_r11: assert property (@(posedge clk) disable iff (rst)
        (src_pulse != '0) |=> ((pend_vec & $past(src_pulse)) == $past(src_pulse)));

    // R4: pending flags only rise on a pulse or an explicit bus write
    p_pend_rise_cause_r4: assert property (@(posedge clk) disable iff (rst)
        (src_pulse == '0 && !bus_wr) |=> ((pend_vec & ~$past(pend_vec)) == '0));

endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  src_state_t [NUM_SRC-1:0] st,
    input  logic [NUM_LVL-1:0]       isr,
    output logic                     valid,
    output logic [SRC_W-1:0]         src,
    output logic [LVL_W-1:0]         level
);

    logic [LVL_W:0] ceiling;

    // Most urgent level in service, or NUM_LVL when none is.
    always_comb begin
        ceiling = (LVL_W+1)'(NUM_LVL);
        for (int l = NUM_LVL-1; l >= 0; l--)
            if (isr[l]) ceiling = (LVL_W+1)'(l);
    end

    always_comb begin
        valid = 1'b0;
        src   = '0;
        level = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (st[i].pend && !st[i].mask && {1'b0, st[i].lvl} < ceiling) begin
                if (!valid || st[i].lvl < level) begin
                    valid = 1'b1;
                    src   = SRC_W'(i);
                    level = st[i].lvl;
                end
            end
        end
    end

endmodule

// File: rtl/prio_intc_isr.sv
module prio_intc_isr
    import prio_intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ack_fire,
    input  logic [LVL_W-1:0]   ack_level,
    input  logic               eoi,
    output logic [NUM_LVL-1:0] isr_q
);

    logic [NUM_LVL-1:0] top_bit;
    logic [NUM_LVL-1:0] isr_d;

    always_comb begin
        top_bit = isr_q & (~isr_q + 1'b1);
        isr_d   = isr_q;
        if (eoi)      isr_d = isr_d & ~top_bit;
        if (ack_fire) isr_d[ack_level] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) isr_q <= '0;
        else     isr_q <= isr_d;
    end

    // R7: acknowledge marks the level in service
    p_ack_sets_level_r7: assert property (@(posedge clk) disable iff (rst)
        ack_fire |=> isr_q[$past(ack_level)]);

    // R8: end-of-interrupt retires exactly one level
    p_eoi_retires_one_r8: assert property (@(posedge clk) disable iff (rst)
        (eoi && !ack_fire && isr_q != '0) |=>
            ($countones(isr_q) == $past($countones(isr_q)) - 1));

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC   = 64,
    parameter int ADDR_W    = 8,
    parameter int CTRL_BASE = 'h00,
    parameter int MASK_BASE = 'h80,
    parameter int ISR_ADDR  = 'hFF,
    localparam int SRC_W    = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic               bus_wr,
    input  logic [1:0]         bus_op,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [2:0]         bus_bit,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    output logic               bus_bit_rd,
    output logic               irq_valid,
    output logic [SRC_W-1:0]   irq_src,
    output logic [2:0]         irq_level,
    input  logic               irq_ack,
    input  logic               eoi
);

    src_state_t [NUM_SRC-1:0] st;
    logic [NUM_LVL-1:0]       isr;
    logic                     ack_fire;

    assign ack_fire = irq_ack && irq_valid;

    prio_intc_regs #(
        .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .CTRL_BASE(CTRL_BASE),
        .MASK_BASE(MASK_BASE), .ISR_ADDR(ISR_ADDR)
    ) regs_i (
        .clk(clk), .rst(rst), .src_pulse(src_pulse),
        .bus_wr(bus_wr), .bus_op(bus_op), .bus_addr(bus_addr),
        .bus_bit(bus_bit), .bus_wdata(bus_wdata),
        .ack_fire(ack_fire), .ack_src(irq_src), .isr(isr),
        .st_q(st), .bus_rdata(bus_rdata), .bus_bit_rd(bus_bit_rd)
    );

    prio_intc_arb #(.NUM_SRC(NUM_SRC)) arb_i (
        .st(st), .isr(isr),
        .valid(irq_valid), .src(irq_src), .level(irq_level)
    );

    prio_intc_isr isr_i (
        .clk(clk), .rst(rst), .ack_fire(ack_fire),
        .ack_level(irq_level), .eoi(eoi), .isr_q(isr)
    );

    // R6: offered level is more urgent than every level in service
    p_valid_unblocked_r6: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> ((isr & ((NUM_LVL'(1) << (irq_level + 1)) - 1'b1)) == '0));

    // R4: an offered source is pending and unmasked
    p_valid_eligible_r4: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (st[irq_src].pend && !st[irq_src].mask));

    // R7: acknowledge consumes the pending flag unless re-requested
    p_ack_clears_pend_r7: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && !src_pulse[irq_src]) |=> !st[$past(irq_src)].pend);

    // R1: nothing is offered right after reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_valid);

endmodule

// File: tb/prio_intc_tb_top.sv
module prio_intc_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS         = 16;
    localparam int SW         = $clog2(NS);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_pulse = '0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_op = 2'd3;
    logic [7:0]    bus_addr = '0;
    logic [2:0]    bus_bit = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          bus_bit_rd;
    logic          irq_valid;
    logic [SW-1:0] irq_src;
    logic [2:0]    irq_level;
    logic          irq_ack = 1'b0;
    logic          eoi = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_intc #(.NUM_SRC(NS)) dut_i (
        .clk(clk), .rst(rst), .src_pulse(src_pulse),
        .bus_wr(bus_wr), .bus_op(bus_op), .bus_addr(bus_addr),
        .bus_bit(bus_bit), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_bit_rd(bus_bit_rd),
        .irq_valid(irq_valid), .irq_src(irq_src), .irq_level(irq_level),
        .irq_ack(irq_ack), .eoi(eoi)
    );

    // vector: {wr, op[1:0], addr[7:0], bit[2:0], wdata[7:0], expected[7:0]}
    function automatic logic [29:0] mkv(input logic w, input logic [1:0] o,
                                        input logic [7:0] a, input logic [2:0] b,
                                        input logic [7:0] d, input logic [7:0] e);
        return {w, o, a, b, d, e};
    endfunction

    localparam int NV = 10;
    localparam logic [29:0] VEC [NV] = '{
        mkv(1, 0, 8'h02, 0, 8'h05, 8'h05),  // R2 control byte write
        mkv(0, 3, 8'h80, 0, 8'h00, 8'hFD),  // R3 seen in mask bank
        mkv(1, 1, 8'h80, 1, 8'h00, 8'hFF),  // R9 bit set in bank
        mkv(0, 3, 8'h02, 0, 8'h00, 8'h45),  // R3 seen in control byte
        mkv(1, 0, 8'h81, 0, 8'h0F, 8'h0F),  // R3 upper bank byte write
        mkv(0, 3, 8'h18, 0, 8'h00, 8'h00),  // R3 source 12 unmasked
        mkv(1, 2, 8'h02, 6, 8'h00, 8'h05),  // R9 bit clear
        mkv(1, 0, 8'hFF, 0, 8'hAA, 8'h00),  // R10 in-service read-only
        mkv(1, 0, 8'h02, 0, 8'h3D, 8'h05),  // R2 bits 5:3 not stored
        mkv(1, 1, 8'h02, 7, 8'h00, 8'h85)   // R9 software sets pending
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_do(input logic [1:0] op, input logic [7:0] a,
                          input logic [2:0] b, input logic [7:0] d);
        bus_wr = 1'b1; bus_op = op; bus_addr = a; bus_bit = b; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_op = 2'd3;
    endtask

    task automatic rd(input logic [7:0] a);
        bus_addr = a;
        #1;
    endtask

    task automatic pulse(input int s);
        src_pulse[s] = 1'b1;
        @(negedge clk);
        src_pulse = '0;
    endtask

    task automatic ack_once();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic eoi_once();
        eoi = 1'b1;
        @(negedge clk);
        eoi = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic [29:0] e;
            e = VEC[v];
            if (e[29]) bus_do(e[28:27], e[26:19], e[18:16], e[15:8]);
            rd(e[26:19]);
            check($sformatf("R2/R3/R9/R10 vector %0d", v), bus_rdata, e[7:0]);
            @(negedge clk);
        end

        // R1 reset state
        do_reset();
        check("R1 irq_valid", irq_valid, 0);
        rd(8'h00); check("R1 control byte", bus_rdata, 8'h40);
        rd(8'h80); check("R1 mask bank", bus_rdata, 8'hFF);
        rd(8'hFF); check("R1 in-service", bus_rdata, 8'h00);

        // R4 masked request stays pending
        bus_do(0, 8'h06, 0, 8'h42);
        pulse(3);
        check("R4 masked no irq", irq_valid, 0);
        rd(8'h06); check("R4 pending latched", bus_rdata, 8'hC2);
        bus_do(2, 8'h80, 3, 8'h00);
        check("R4 delivered on unmask", {irq_valid, 4'(irq_src), irq_level}, {1'b1, 4'd3, 3'd2});

        // R5 tie and priority
        bus_do(0, 8'h0A, 0, 8'h02);
        pulse(5);
        check("R5 tie lowest index", irq_src, 3);
        bus_do(0, 8'h0E, 0, 8'h01);
        pulse(7);
        check("R5 lower level wins", {4'(irq_src), irq_level}, {4'd7, 3'd1});

        // R7 acknowledge
        ack_once();
        rd(8'hFF); check("R7 in-service set", bus_rdata, 8'h02);
        rd(8'h0E); check("R7 pending cleared", bus_rdata, 8'h01);
        check("R6 lower level blocked", irq_valid, 0);
        bus_do(0, 8'h0A, 0, 8'h81);
        check("R6 equal level blocked", irq_valid, 0);
        bus_do(0, 8'h0A, 0, 8'h82);

        // R6 more urgent preempts
        bus_do(0, 8'h12, 0, 8'h00);
        pulse(9);
        check("R6 more urgent offered", {irq_valid, 4'(irq_src), irq_level}, {1'b1, 4'd9, 3'd0});
        ack_once();
        rd(8'hFF); check("R7 nested in-service", bus_rdata, 8'h03);

        // R8 end of interrupt
        eoi_once();
        rd(8'hFF); check("R8 top level retired", bus_rdata, 8'h02);
        check("R8 still blocked", irq_valid, 0);
        eoi_once();
        check("R8 released", {irq_valid, 4'(irq_src), irq_level}, {1'b1, 4'd3, 3'd2});

        // R4 software clears pending before delivery
        bus_do(2, 8'h06, 7, 8'h00);
        check("R4 cleared pending skipped", irq_src, 5);

        // R9 bit read
        bus_addr = 8'h0A; bus_bit = 3'd7; #1;
        check("R9 bit read", bus_bit_rd, 1);

        // R11 pulse wins over clear
        src_pulse[5] = 1'b1;
        bus_do(2, 8'h0A, 7, 8'h00);
        src_pulse = '0;
        rd(8'h0A); check("R11 pulse beats clear", bus_rdata, 8'h82);
        bus_do(2, 8'h0A, 7, 8'h00);
        rd(8'h0A); check("R9 clear pending only", bus_rdata, 8'h02);
        check("R4 nothing left", irq_valid, 0);

        finish_run();
    end

endmodule